// File: doc/BRIEF.md
# Synchronous Exception Routing and Return Address Unit

This unit resolves one synchronous exception per request. It handles two exception kinds, a data abort and a supervisor call. For each one it returns four results: the privilege level (0 to 3) that takes the exception, the preferred return address to save, the offset into the vector table, and the low syndrome bits. The surrounding core supplies the current level, the routing-control bits, the fault attributes, the address of the current instruction, its encoding size and the 16-bit call immediate. The unit does not write system registers, look up the vector base or save state.

A data abort returns to the faulting instruction so that it runs again. A supervisor call returns to the instruction that follows it. Data-abort routing applies its trap controls in layers: level 3 is checked first, then level 2, then level 1. An external abort that reaches level 3, with error exceptions enabled, uses the dedicated error vector offset.

The block is a two-state machine. In `ST_IDLE` it waits for a request. A request moves it to `ST_DONE` (transition IDLE->DONE), and the results are registered on that same edge. Another request while in `ST_DONE` keeps it there (DONE->DONE) and loads new results. With no request it returns to `ST_IDLE` (DONE->IDLE) and the results are held.

Top module: `exc_route_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `rsp_valid_o` is 0 and `tgt_el_o`, `ret_addr_o`, `vec_off_o` and `syn_o` are all zero.
- R2: `rsp_valid_o` is 1 in exactly the cycle after each cycle in which `req_i` is 1 at the rising edge, and 0 otherwise. The results in that cycle belong to that request.
- R3: For a data abort (`kind_i` = 0), `ret_addr_o` equals `pc_i`.
- R4: For a supervisor call (`kind_i` = 1), `ret_addr_o` equals `pc_i` + 4 when `isz32_i` = 1 and `pc_i` + 2 when `isz32_i` = 0, wrapping modulo 2^ADDR_W.
- R5: A data abort targets level 3 when the current level is 3, or when level 3 is implemented, `ext_route_i` = 1 and `is_ext_i` = 1.
- R6: Otherwise, a data abort targets level 2 when the current level is 2. It also targets level 2 when the current level is 0 or 1, `el2_en_i` = 1, and at least one of these holds: `trap_gen_i` = 1; RAS support is present with `ras_trap_i` = 1 and `is_ext_i` = 1; or `is_s2_i` = 1.
- R7: A data abort that matches neither R5 nor R6 targets level 1.
- R8: The vector offset is 0x180 when double-fault support is present, the kind is data abort, the target is level 3, `is_ext_i` = 1 and `err_en_i` = 1. In every other case it is 0x000.
- R9: A supervisor call from level 2 or 3 targets the current level. From level 0 it targets level 2 when `el2_en_i` = 1 and `trap_gen_i` = 1. In all other cases it targets level 1.
- R10: For a supervisor call, `syn_o` equals `imm_i` and `vec_off_o` is 0. For a data abort, `syn_o` is 0.
- R11: When there is no request, all result outputs keep the values of the last response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Resolve request |
| kind_i | input | 1 | 0 = data abort, 1 = supervisor call |
| cur_el_i | input | 2 | Current privilege level |
| el2_en_i | input | 1 | Level 2 enabled |
| trap_gen_i | input | 1 | General trap-to-level-2 control |
| ras_trap_i | input | 1 | External-abort trap-to-level-2 control |
| ext_route_i | input | 1 | External-abort route-to-level-3 control |
| err_en_i | input | 1 | Error-exception vector enable |
| is_ext_i | input | 1 | Fault is an external abort |
| is_s2_i | input | 1 | Fault is a second-stage fault |
| pc_i | input | ADDR_W | Current instruction address |
| isz32_i | input | 1 | 1 = 4-byte encoding, 0 = 2-byte encoding |
| imm_i | input | IMM_W | Supervisor call immediate |
| rsp_valid_o | output | 1 | Results valid |
| tgt_el_o | output | 2 | Target privilege level |
| ret_addr_o | output | ADDR_W | Preferred return address |
| vec_off_o | output | VEC_W | Vector offset |
| syn_o | output | IMM_W | Low syndrome bits |

## Verification
The properties assume that request inputs are stable around the rising edge at which `req_i` is sampled, and that `kind_i` and `cur_el_i` are never X during a request. The stimulus changes every input only on the falling clock edge. Each request it issues carries a complete, fully defined set of attributes. The stimulus also keeps to legal combinations: it never issues a data abort at level 3 while level 3 is declared absent, and a supervisor call from level 2 is only issued when level 2 is enabled.

// File: rtl/exc_route_pkg.sv
package exc_route_pkg;
    typedef logic [1:0] el_t;

    localparam el_t LVL0 = 2'd0;
    localparam el_t LVL1 = 2'd1;
    localparam el_t LVL2 = 2'd2;
    localparam el_t LVL3 = 2'd3;

    typedef enum logic {
        EXC_DABT = 1'b0,
        EXC_SVC  = 1'b1
    } exc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/exc_dabt_route.sv
module exc_dabt_route
    import exc_route_pkg::*;
#(
    parameter bit HAS_EL3  = 1'b1,
    parameter bit HAS_RAS  = 1'b1,
    parameter bit HAS_DFLT = 1'b1,
    parameter int VEC_W    = 12
) (
    input  el_t              cur_el_i,
    input  logic             el2_en_i,
    input  logic             trap_gen_i,
    input  logic             ras_trap_i,
    input  logic             ext_route_i,
    input  logic             err_en_i,
    input  logic             is_ext_i,
    input  logic             is_s2_i,
    output el_t              tgt_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] VEC_SERR = VEC_W'(12'h180);

    logic ras_hit;
    logic up_l3;
    logic up_l2;
    logic from_low;

    generate
        if (HAS_RAS) begin : g_ras
            assign ras_hit = ras_trap_i & is_ext_i;
        end else begin : g_no_ras
            assign ras_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        from_low = (cur_el_i == LVL0) || (cur_el_i == LVL1);
        up_l3    = HAS_EL3 && ext_route_i && is_ext_i;
        up_l2    = from_low && el2_en_i && (trap_gen_i || ras_hit || is_s2_i);

        if ((cur_el_i == LVL3) || up_l3) begin
            tgt_o = LVL3;
        end else if ((cur_el_i == LVL2) || up_l2) begin
            tgt_o = LVL2;
        end else begin
            tgt_o = LVL1;
        end

        if (HAS_DFLT && (tgt_o == LVL3) && is_ext_i && err_en_i) begin
            vec_o = VEC_SERR;
        end else begin
            vec_o = '0;
        end
    end
endmodule

// File: rtl/exc_svc_route.sv
module exc_svc_route
    import exc_route_pkg::*;
(
    input  el_t  cur_el_i,
    input  logic el2_en_i,
    input  logic trap_gen_i,
    output el_t  tgt_o
);
    always_comb begin
        if (cur_el_i > LVL1) begin
            tgt_o = cur_el_i;
        end else if ((cur_el_i == LVL0) && el2_en_i && trap_gen_i) begin
            tgt_o = LVL2;
        end else begin
            tgt_o = LVL1;
        end
    end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr
    import exc_route_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  exc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              isz32_i,
    output logic [ADDR_W-1:0] ret_o
);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);

    always_comb begin
        unique case (kind_i)
            EXC_DABT: ret_o = pc_i;
            EXC_SVC:  ret_o = pc_i + (isz32_i ? STEP_WIDE : STEP_NARROW);
            default:  ret_o = pc_i;
        endcase
    end
endmodule

// File: rtl/exc_route_unit.sv
module exc_route_unit
    import exc_route_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int IMM_W    = 16,
    parameter int VEC_W    = 12,
    parameter bit HAS_EL3  = 1'b1,
    parameter bit HAS_RAS  = 1'b1,
    parameter bit HAS_DFLT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              kind_i,
    input  logic [1:0]        cur_el_i,
    input  logic              el2_en_i,
    input  logic              trap_gen_i,
    input  logic              ras_trap_i,
    input  logic              ext_route_i,
    input  logic              err_en_i,
    input  logic              is_ext_i,
    input  logic              is_s2_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              isz32_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              rsp_valid_o,
    output logic [1:0]        tgt_el_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic [VEC_W-1:0]  vec_off_o,
    output logic [IMM_W-1:0]  syn_o
);
    rsp_state_e        state_q, state_d;
    exc_kind_e         kind;
    el_t               dabt_tgt, svc_tgt, tgt_d;
    logic [VEC_W-1:0]  dabt_vec, vec_d;
    logic [ADDR_W-1:0] ret_d;
    logic [IMM_W-1:0]  syn_d;

    assign kind = exc_kind_e'(kind_i);

    exc_dabt_route #(
        .HAS_EL3 (HAS_EL3),
        .HAS_RAS (HAS_RAS),
        .HAS_DFLT(HAS_DFLT),
        .VEC_W   (VEC_W)
    ) dabt_i (
        .cur_el_i   (cur_el_i),
        .el2_en_i   (el2_en_i),
        .trap_gen_i (trap_gen_i),
        .ras_trap_i (ras_trap_i),
        .ext_route_i(ext_route_i),
        .err_en_i   (err_en_i),
        .is_ext_i   (is_ext_i),
        .is_s2_i    (is_s2_i),
        .tgt_o      (dabt_tgt),
        .vec_o      (dabt_vec)
    );

    exc_svc_route svc_i (
        .cur_el_i  (cur_el_i),
        .el2_en_i  (el2_en_i),
        .trap_gen_i(trap_gen_i),
        .tgt_o     (svc_tgt)
    );

    exc_ret_addr #(.ADDR_W(ADDR_W)) ret_i (
        .kind_i (kind),
        .pc_i   (pc_i),
        .isz32_i(isz32_i),
        .ret_o  (ret_d)
    );

    always_comb begin
        unique case (kind)
            EXC_DABT: begin
                tgt_d = dabt_tgt;
                vec_d = dabt_vec;
                syn_d = '0;
            end
            EXC_SVC: begin
                tgt_d = svc_tgt;
                vec_d = '0;
                syn_d = imm_i;
            end
            default: begin
                tgt_d = LVL1;
                vec_d = '0;
                syn_d = '0;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_DONE;
            ST_DONE: state_d = req_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_el_o   <= '0;
            ret_addr_o <= '0;
            vec_off_o  <= '0;
            syn_o      <= '0;
        end else if (req_i) begin
            tgt_el_o   <= tgt_d;
            ret_addr_o <= ret_d;
            vec_off_o  <= vec_d;
            syn_o      <= syn_d;
        end
    end

    assign rsp_valid_o = (state_q == ST_DONE);
endmodule

// File: rtl/exc_route_chk.sv
module exc_route_chk #(
    parameter int ADDR_W = 64,
    parameter int IMM_W  = 16,
    parameter int VEC_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              kind_i,
    input logic [1:0]        cur_el_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              rsp_valid_o,
    input logic [1:0]        tgt_el_o,
    input logic [ADDR_W-1:0] ret_addr_o,
    input logic [VEC_W-1:0]  vec_off_o,
    input logic [IMM_W-1:0]  syn_o
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_valid_o);

    // R11
    hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(tgt_el_o) && $stable(ret_addr_o) &&
                    $stable(vec_off_o) && $stable(syn_o)));

    // R3
    dabt_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !kind_i) |=> (ret_addr_o == $past(pc_i)));

    // R10
    svc_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i) |=> (syn_o == $past(imm_i) && vec_off_o == '0));

    // R9
    svc_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i && cur_el_i[1]) |=> (tgt_el_o == $past(cur_el_i)));

    // R5
    dabt_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !kind_i && cur_el_i == 2'd3) |=> (tgt_el_o == 2'd3));

    // R8
    vec_only_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && vec_off_o != '0) |-> (tgt_el_o == 2'd3));
endmodule

bind exc_route_unit exc_route_chk #(
    .ADDR_W(ADDR_W),
    .IMM_W (IMM_W),
    .VEC_W (VEC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .kind_i     (kind_i),
    .cur_el_i   (cur_el_i),
    .pc_i       (pc_i),
    .imm_i      (imm_i),
    .rsp_valid_o(rsp_valid_o),
    .tgt_el_o   (tgt_el_o),
    .ret_addr_o (ret_addr_o),
    .vec_off_o  (vec_off_o),
    .syn_o      (syn_o)
);

// File: tb/exc_route_unit_tb_top.sv
module exc_route_unit_tb_top;
    localparam int ADDR_W = 64;
    localparam int IMM_W  = 16;
    localparam int VEC_W  = 12;

    typedef struct {
        logic [1:0]        tgt;
        logic [ADDR_W-1:0] ret;
        logic [VEC_W-1:0]  vec;
        logic [IMM_W-1:0]  syn;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              kind_i = 1'b0;
    logic [1:0]        cur_el_i = '0;
    logic              el2_en_i = 1'b0, trap_gen_i = 1'b0, ras_trap_i = 1'b0;
    logic              ext_route_i = 1'b0, err_en_i = 1'b0;
    logic              is_ext_i = 1'b0, is_s2_i = 1'b0;
    logic [ADDR_W-1:0] pc_i = '0;
    logic              isz32_i = 1'b1;
    logic [IMM_W-1:0]  imm_i = '0;
    logic              rsp_valid_o;
    logic [1:0]        tgt_el_o;
    logic [ADDR_W-1:0] ret_addr_o;
    logic [VEC_W-1:0]  vec_off_o;
    logic [IMM_W-1:0]  syn_o;

    int   total = 0;
    int   bad = 0;
    exp_t sb_q[$];
    exp_t last;
    bit   have_last = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    exc_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
        .cur_el_i(cur_el_i), .el2_en_i(el2_en_i), .trap_gen_i(trap_gen_i),
        .ras_trap_i(ras_trap_i), .ext_route_i(ext_route_i), .err_en_i(err_en_i),
        .is_ext_i(is_ext_i), .is_s2_i(is_s2_i), .pc_i(pc_i), .isz32_i(isz32_i),
        .imm_i(imm_i), .rsp_valid_o(rsp_valid_o), .tgt_el_o(tgt_el_o),
        .ret_addr_o(ret_addr_o), .vec_off_o(vec_off_o), .syn_o(syn_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected results from the requirement text (R3..R10), all options present
    function automatic exp_t model(bit k, logic [1:0] el, bit e2, bit tg, bit rt,
                                   bit er, bit ee, bit ext, bit s2,
                                   logic [ADDR_W-1:0] pc, bit w, logic [IMM_W-1:0] imm);
        exp_t r;
        r.vec = '0;
        if (!k) begin
            r.ret = pc;
            r.syn = '0;
            if (el == 2'd3 || (er && ext)) r.tgt = 2'd3;
            else if (el == 2'd2 || (el < 2'd2 && e2 && (tg || (rt && ext) || s2))) r.tgt = 2'd2;
            else r.tgt = 2'd1;
            if (r.tgt == 2'd3 && ext && ee) r.vec = 12'h180;
        end else begin
            r.ret = pc + (w ? 64'd4 : 64'd2);
            r.syn = imm;
            if (el >= 2'd2) r.tgt = el;
            else if (el == 2'd0 && e2 && tg) r.tgt = 2'd2;
            else r.tgt = 2'd1;
        end
        return r;
    endfunction

    // driver: called just after a falling edge; returns at the next falling edge
    task automatic send(string tag, bit k, logic [1:0] el, bit e2, bit tg, bit rt,
                        bit er, bit ee, bit ext, bit s2,
                        logic [ADDR_W-1:0] pc, bit w, logic [IMM_W-1:0] imm);
        exp_t e;
        e = model(k, el, e2, tg, rt, er, ee, ext, s2, pc, w, imm);
        e.tag = tag;
        req_i = 1'b1; kind_i = k; cur_el_i = el; el2_en_i = e2; trap_gen_i = tg;
        ras_trap_i = rt; ext_route_i = er; err_en_i = ee; is_ext_i = ext;
        is_s2_i = s2; pc_i = pc; isz32_i = w; imm_i = imm;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_i = 1'b0;
        kind_i = 1'b1; cur_el_i = 2'd3; pc_i = '1; imm_i = '1; ext_route_i = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid_o) begin
                if (sb_q.size() == 0) begin
                    check("R2 unexpected response", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " target"}, 64'(tgt_el_o), 64'(e.tgt));
                    check({e.tag, " return"}, ret_addr_o, e.ret);
                    check({e.tag, " vector"}, 64'(vec_off_o), 64'(e.vec));
                    check({e.tag, " syndrome"}, 64'(syn_o), 64'(e.syn));
                    last = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                // R11: results held while idle
                check("R11 hold", {tgt_el_o, vec_off_o, syn_o},
                      {last.tgt, last.vec, last.syn});
                check("R11 hold return", ret_addr_o, last.ret);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 64'(rsp_valid_o), 64'd0);
        check("R1 results", {tgt_el_o, vec_off_o, syn_o}, 64'd0);
        check("R1 return", ret_addr_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 64'(rsp_valid_o), 64'd0);

        // data aborts: R3 R5 R6 R7 R8
        send("R7 dabt el0 plain", 0, 0, 0,0,0,0,0,0,0, 64'h1000, 1, 0); idle(2);
        send("R5 R8 dabt ext route vec", 0, 1, 0,0,0,1,1,1,0, 64'h2000, 1, 0); idle(1);
        send("R5 R8 dabt ext route no err", 0, 0, 0,0,0,1,0,1,0, 64'h2004, 1, 0); idle(1);
        send("R5 dabt route but not ext", 0, 0, 0,0,0,1,1,0,0, 64'h2008, 1, 0); idle(1);
        send("R5 dabt from el3", 0, 3, 0,0,0,0,1,0,0, 64'h3000, 1, 0); idle(1);
        send("R8 dabt el3 ext err", 0, 3, 0,0,0,0,1,1,0, 64'h3004, 1, 0); idle(1);
        send("R6 dabt gen trap", 0, 1, 1,1,0,0,0,0,0, 64'h4000, 1, 0); idle(1);
        send("R7 dabt trap no el2", 0, 1, 0,1,0,0,0,0,0, 64'h4004, 1, 0); idle(1);
        send("R6 dabt ras ext", 0, 0, 1,0,1,0,0,1,0, 64'h4008, 1, 0); idle(1);
        send("R7 dabt ras not ext", 0, 0, 1,0,1,0,0,0,0, 64'h400c, 1, 0); idle(1);
        send("R6 dabt stage2", 0, 1, 1,0,0,0,0,0,1, 64'h4010, 0, 0); idle(1);
        send("R6 dabt from el2", 0, 2, 1,0,0,0,1,1,0, 64'h5000, 1, 0); idle(1);
        send("R8 dabt el2 ext err no vec", 0, 2, 1,0,0,0,1,1,0, 64'h5004, 1, 0); idle(1);

        // supervisor calls: R4 R9 R10
        send("R9 svc el0", 1, 0, 0,0,0,0,0,0,0, 64'h6000, 1, 16'h1234); idle(1);
        send("R9 svc el0 trap", 1, 0, 1,1,0,0,0,0,0, 64'h6000, 0, 16'hbeef); idle(1);
        send("R9 svc el1 trap", 1, 1, 1,1,0,0,0,0,0, 64'h6100, 1, 16'h0001); idle(1);
        send("R9 svc el2", 1, 2, 1,1,0,1,1,1,0, 64'h6200, 1, 16'hffff); idle(1);
        send("R9 R10 svc el3", 1, 3, 0,0,0,1,1,1,1, 64'h6300, 0, 16'h8000); idle(1);
        send("R4 svc wrap", 1, 1, 0,0,0,0,0,0,0, 64'hffff_ffff_ffff_fffe, 1, 16'h00aa); idle(1);
        send("R4 svc narrow", 1, 1, 0,0,0,0,0,0,0, 64'h0000_0000_0000_7ffe, 0, 16'h5555); idle(2);

        // R2 back-to-back requests
        send("R2 b2b first", 0, 1, 1,1,0,0,0,0,0, 64'h7000, 1, 0);
        send("R2 b2b second", 1, 0, 0,0,0,0,0,0,0, 64'h7004, 1, 16'h0042);
        send("R2 b2b third", 0, 0, 0,0,0,1,1,1,0, 64'h7008, 0, 0);
        idle(4);

        check("R2 all responses seen", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule